// File: doc/BRIEF.md
# NAND Address Cycle Sequencer

This block turns one address request into the chain of byte-wide address cycles that a NAND flash expects after a command. A request carries a column value and a page (row) value. Each has a valid flag, so either part can be left out. A two-bit page-size setting picks small-page (512 B), 2K-page or 4K-page layout. A page mask sets how many row bytes go out.

For every address byte the sequencer works in four steps. It clears the flash-side status flag. It puts the byte on `addr_byte` and pulses `addr_go`. It then samples `op_done` once per poll interval. When it sees the flag it clears it again before moving to the next byte. If the flag never arrives within the poll budget, the sequencer records a sticky timeout and continues with the next byte rather than stalling. Pin-level flash timing is outside this block: the flash side only has to raise `op_done` when an address operation has completed.

A controller pulses `start` with the request fields valid in that cycle. It then watches `busy`, and the one-cycle `done` pulse tells it the sequence has finished.

Top module: `nand_addr_seq`

## Requirements
- R1: When the column part is present, the first address byte issued is col[7:0].
- R2: With page_mode = 2'b01 (2K page), a second column byte follows, equal to {4'b0, col[11:8]}.
- R3: With page_mode = 2'b10 (4K page), a second column byte follows, equal to {3'b0, col[12:8]}.
- R4: With page_mode = 2'b00 or 2'b11 (small page), exactly one column byte is issued.
- R5: Row bytes follow the column bytes. They are page_addr taken 8 bits at a time, least significant byte first. After each row byte both the address and the mask shift right by 8, and the row bytes end once the shifted mask is zero. At least one row byte is always sent.
- R6: col_valid = 0 skips every column byte. row_valid = 0 skips every row byte. With both low, the sequence ends with done and issues no byte.
- R7: Each byte is preceded by a one-cycle stat_clr pulse in the cycle just before its addr_go pulse. An observed op_done is acknowledged by another one-cycle stat_clr pulse before the next byte.
- R8: op_done is sampled once every CLK_MHZ cycles, at most POLL_LIMIT times per byte. When the polls run out, tmo_err is set and the sequencer moves on to the next byte. tmo_err holds until the next accepted start clears it.
- R9: busy is high from the cycle after an accepted start through the cycle of the one-cycle done pulse. No addr_go occurs while busy is low.
- R10: A start pulse while busy is high is ignored and does not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request pulse |
| col_valid | input | 1 | Column part present |
| col | input | COL_W | Column address |
| row_valid | input | 1 | Row part present |
| page_addr | input | ROW_W | Page (row) address |
| page_mask | input | ROW_W | Mask that sets the row byte count |
| page_mode | input | 2 | 00/11 small, 01 2K, 10 4K |
| op_done | input | 1 | Flash-side status flag for the address operation |
| addr_byte | output | 8 | Address byte for the current cycle |
| addr_go | output | 1 | Start one address operation |
| stat_clr | output | 1 | Clear the flash-side status flag |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| tmo_err | output | 1 | Sticky poll timeout flag |

## Verification
The bench builds the block with CLK_MHZ = 4 and POLL_LIMIT = 5. A full poll window therefore lasts 20 cycles instead of 400,000. This makes it cheap to run whole sequences in which the flash never answers, and to check the exact busy length of such a sequence and the give-up-and-continue behaviour across several bytes. A flash model in the bench plants a stale status flag before requests. This exposes any byte that is launched without the flag being cleared first.

// File: rtl/nand_addr_pkg.sv
// Shared encodings for the NAND address cycle sequencer.
// Assumes page_mode codes are fixed by the requirements (00/11 small, 01 2K, 10 4K).
package nand_addr_pkg;
    localparam logic [1:0] PG_2K = 2'b01;
    localparam logic [1:0] PG_4K = 2'b10;

    typedef enum logic [1:0] {
        PH_COL_LO = 2'd0,
        PH_COL_HI = 2'd1,
        PH_ROW    = 2'd2
    } phase_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CLR  = 3'd1,
        ST_GO   = 3'd2,
        ST_WAIT = 3'd3,
        ST_ACK  = 3'd4,
        ST_FIN  = 3'd5
    } state_e;
endpackage

// File: rtl/nand_poll_timer.sv
// Poll pacing and poll budget for one address byte.
// Produces a tick every TICK_DIV cycles while run is high. last flags the
// final allowed poll. Assumes TICK_DIV >= 1 and POLL_LIMIT >= 1.
module nand_poll_timer #(
    parameter int TICK_DIV   = 200,
    parameter int POLL_LIMIT = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick,
    output logic last
);
    localparam int PRE_W = $clog2(TICK_DIV + 1);
    localparam int CNT_W = $clog2(POLL_LIMIT + 1);
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(TICK_DIV - 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(POLL_LIMIT - 1);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] polls_q;

    assign tick = run && (pre_q == PRE_TOP);
    assign last = (polls_q == CNT_TOP);

    // Prescaler and poll counter, restarted at each byte launch.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pre_q   <= '0;
            polls_q <= '0;
        end else if (run) begin
            if (tick) begin
                pre_q <= '0;
                if (!last) polls_q <= polls_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/nand_addr_byte_sel.sv
// Chooses the address byte for the current phase.
// Column high byte is masked by page mode; row byte is the low byte of the
// already shifted page address.
module nand_addr_byte_sel
    import nand_addr_pkg::*;
#(
    parameter int COL_W = 16
) (
    input  phase_e           phase,
    input  logic [1:0]       mode,
    input  logic [COL_W-1:0] col,
    input  logic [7:0]       row_lo,
    output logic [7:0]       byte_out
);
    logic [15:0] col_ext;
    assign col_ext = 16'(col);

    // Byte select per phase and page mode.
    always_comb begin
        byte_out = row_lo;
        unique case (phase)
            PH_COL_LO: byte_out = col_ext[7:0];
            PH_COL_HI: begin
                if (mode == PG_4K) byte_out = {3'b000, col_ext[12:8]};
                else               byte_out = {4'b0000, col_ext[11:8]};
            end
            default:   byte_out = row_lo;
        endcase
    end
endmodule

// File: rtl/nand_addr_seq.sv
// NAND address cycle sequencer (top).
// Issues column then row address bytes. Each byte is bracketed by a
// status clear, a launch pulse, a paced poll of op_done and an acknowledge
// clear. Assumes op_done is a level flag cleared by stat_clr on the flash side.
module nand_addr_seq
    import nand_addr_pkg::*;
#(
    parameter int COL_W      = 16,
    parameter int ROW_W      = 32,
    parameter int CLK_MHZ    = 200,
    parameter int POLL_LIMIT = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             col_valid,
    input  logic [COL_W-1:0] col,
    input  logic             row_valid,
    input  logic [ROW_W-1:0] page_addr,
    input  logic [ROW_W-1:0] page_mask,
    input  logic [1:0]       page_mode,
    input  logic             op_done,
    output logic [7:0]       addr_byte,
    output logic             addr_go,
    output logic             stat_clr,
    output logic             busy,
    output logic             done,
    output logic             tmo_err
);
    state_e           state_q;
    phase_e           phase_q, nxt_phase;
    logic [1:0]       mode_q;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q, mask_q, mask_nxt;
    logic             row_en_q, nxt_more, tick, last, seq_adv, err_q;

    assign mask_nxt = mask_q >> 8;

    nand_poll_timer #(.TICK_DIV(CLK_MHZ), .POLL_LIMIT(POLL_LIMIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(state_q == ST_GO),
        .run(state_q == ST_WAIT), .tick(tick), .last(last)
    );

    nand_addr_byte_sel #(.COL_W(COL_W)) u_sel (
        .phase(phase_q), .mode(mode_q), .col(col_q),
        .row_lo(row_q[7:0]), .byte_out(addr_byte)
    );

    // Leave the current byte on acknowledge or on poll exhaustion.
    assign seq_adv = (state_q == ST_ACK) ||
                     (state_q == ST_WAIT && tick && !op_done && last);

    // Decide which byte, if any, follows the current one.
    always_comb begin
        nxt_more  = 1'b0;
        nxt_phase = PH_ROW;
        unique case (phase_q)
            PH_COL_LO: begin
                if (mode_q == PG_2K || mode_q == PG_4K) begin
                    nxt_more  = 1'b1;
                    nxt_phase = PH_COL_HI;
                end else begin
                    nxt_more = row_en_q;
                end
            end
            PH_COL_HI: nxt_more = row_en_q;
            default:   nxt_more = (mask_nxt != '0);
        endcase
    end

    // Handshake state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) state_q <= (col_valid || row_valid) ? ST_CLR : ST_FIN;
                ST_CLR:  state_q <= ST_GO;
                ST_GO:   state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (tick && op_done) state_q <= ST_ACK;
                    else if (seq_adv)    state_q <= nxt_more ? ST_CLR : ST_FIN;
                end
                ST_ACK:  state_q <= nxt_more ? ST_CLR : ST_FIN;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Request capture and per-byte address bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_COL_LO;
            mode_q   <= '0;
            col_q    <= '0;
            row_q    <= '0;
            mask_q   <= '0;
            row_en_q <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            phase_q  <= col_valid ? PH_COL_LO : PH_ROW;
            mode_q   <= page_mode;
            col_q    <= col;
            row_q    <= page_addr;
            mask_q   <= page_mask;
            row_en_q <= row_valid;
        end else if (seq_adv) begin
            phase_q <= nxt_phase;
            if (phase_q == PH_ROW) begin
                row_q  <= row_q >> 8;
                mask_q <= mask_nxt;
            end
        end
    end

    // Sticky timeout flag, cleared by an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)                          err_q <= 1'b0;
        else if (state_q == ST_IDLE && start) err_q <= 1'b0;
        else if (state_q == ST_WAIT && tick && !op_done && last) err_q <= 1'b1;
    end

    assign tmo_err  = err_q;
    assign addr_go  = (state_q == ST_GO);
    assign stat_clr = (state_q == ST_CLR) || (state_q == ST_ACK);
    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_FIN);
endmodule

// File: rtl/nand_addr_seq_chk.sv
// Port-level protocol checks for nand_addr_seq, attached with bind.
module nand_addr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       op_done,
    input logic [7:0] addr_byte,
    input logic       addr_go,
    input logic       stat_clr,
    input logic       busy,
    input logic       done,
    input logic       tmo_err
);
    AST_GO_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        addr_go |-> $past(stat_clr)); // R7
    AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        addr_go |=> $stable(addr_byte)); // R1
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_GO_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !addr_go); // R9
    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_err && !(start && !busy)) |=> tmo_err); // R8
    AST_ERR_RISE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_err) |-> $past(busy)); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy); // R10
endmodule

bind nand_addr_seq nand_addr_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op_done(op_done),
    .addr_byte(addr_byte), .addr_go(addr_go), .stat_clr(stat_clr),
    .busy(busy), .done(done), .tmo_err(tmo_err)
);

// File: tb/tb_nand_addr_seq.sv
module tb_nand_addr_seq;
    localparam int CLK_MHZ    = 4;
    localparam int POLL_LIMIT = 5;

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic        col_valid = 1'b0, row_valid = 1'b0;
    logic [15:0] col = '0;
    logic [31:0] page_addr = '0, page_mask = '0;
    logic [1:0]  page_mode = '0;
    logic        flag = 1'b0;
    logic [7:0]  addr_byte;
    logic        addr_go, stat_clr, busy, done, tmo_err;

    int checks = 0, fails = 0;
    logic [7:0] log_b [16];
    int n_log = 0, n_done = 0, n_busy = 0, n_clr = 0, n_stale = 0;
    int cnt = 0;
    logic respond = 1'b1;
    logic [7:0] exp_b [16];
    int n_exp = 0;

    always #2.5 clk = ~clk;

    nand_addr_seq #(.COL_W(16), .ROW_W(32), .CLK_MHZ(CLK_MHZ), .POLL_LIMIT(POLL_LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .col_valid(col_valid), .col(col),
        .row_valid(row_valid), .page_addr(page_addr), .page_mask(page_mask),
        .page_mode(page_mode), .op_done(flag), .addr_byte(addr_byte),
        .addr_go(addr_go), .stat_clr(stat_clr), .busy(busy), .done(done),
        .tmo_err(tmo_err)
    );

    // Flash-side model: logs bytes, raises the flag after a delay, clears on stat_clr.
    always @(negedge clk) begin
        if (rst_n) begin
            if (stat_clr) begin flag = 1'b0; n_clr++; end
            if (done) n_done++;
            if (busy) n_busy++;
            if (addr_go) begin
                if (flag) n_stale++;
                if (n_log < 16) log_b[n_log] = addr_byte;
                n_log++;
                cnt = respond ? 3 : 0;
            end else if (cnt > 0) begin
                cnt--;
                if (cnt == 0) flag = 1'b1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic build_exp(input logic cv, input logic [15:0] c, input logic rv,
                             input logic [31:0] pa, input logic [31:0] pm, input logic [1:0] md);
        logic [31:0] a = pa, m = pm;
        n_exp = 0;
        if (cv) begin
            exp_b[n_exp++] = c[7:0];
            if (md == 2'b01) exp_b[n_exp++] = {4'b0, c[11:8]};
            else if (md == 2'b10) exp_b[n_exp++] = {3'b0, c[12:8]};
        end
        if (rv) begin
            do begin
                exp_b[n_exp++] = a[7:0];
                a = a >> 8;
                m = m >> 8;
            end while (m != 0);
        end
    endtask

    task automatic launch(input logic cv, input logic [15:0] c, input logic rv,
                          input logic [31:0] pa, input logic [31:0] pm, input logic [1:0] md);
        n_log = 0; n_done = 0; n_busy = 0; n_clr = 0; n_stale = 0;
        flag = 1'b1;  // stale status left over from earlier activity
        @(negedge clk); #1;
        col_valid = cv; col = c; row_valid = rv; page_addr = pa; page_mask = pm; page_mode = md;
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000 && n_done == 0; i++) begin
            @(negedge clk); #1;
        end
        @(negedge clk); #1;
    endtask

    task automatic cmp_bytes(input string req);
        chk(req, n_log, n_exp, "byte count");
        for (int i = 0; i < n_exp && i < n_log; i++)
            chk(req, int'(log_b[i]), int'(exp_b[i]), $sformatf("byte %0d", i));
    endtask

    task automatic run_seq(input string req, input logic cv, input logic [15:0] c, input logic rv,
                           input logic [31:0] pa, input logic [31:0] pm, input logic [1:0] md);
        build_exp(cv, c, rv, pa, pm, md);
        launch(cv, c, rv, pa, pm, md);
        wait_done();
        cmp_bytes(req);
        chk("R9", n_done, 1, "done pulses");
        chk("R7", n_stale, 0, "byte launched with stale flag");
    endtask

    task automatic t_reset();
        chk("R9", int'(busy), 0, "busy after reset");
        chk("R9", int'(done), 0, "done after reset");
        chk("R8", int'(tmo_err), 0, "tmo_err after reset");
        chk("R9", int'(addr_go), 0, "addr_go after reset");
    endtask

    task automatic t_small();  // R1 R4 R5
        run_seq("R4", 1'b1, 16'h1234, 1'b1, 32'h00A5_B6C7, 32'h0003_FFFF, 2'b00);
        chk("R7", n_clr, 2 * n_exp, "stat_clr pulses");
        run_seq("R1", 1'b1, 16'hFF5A, 1'b1, 32'h0000_0077, 32'h0000_00FF, 2'b11);
    endtask

    task automatic t_2k();  // R2
        run_seq("R2", 1'b1, 16'hABCD, 1'b1, 32'h0000_3C4D, 32'h0000_FFFF, 2'b01);
        chk("R8", int'(tmo_err), 0, "no timeout when answered");
    endtask

    task automatic t_4k();  // R3
        run_seq("R3", 1'b1, 16'hFFFF, 1'b1, 32'h0102_0304, 32'h00FF_FFFF, 2'b10);
        run_seq("R3", 1'b1, 16'h0E21, 1'b0, 32'h0, 32'h0, 2'b10);
    endtask

    task automatic t_rows();  // R5
        run_seq("R5", 1'b0, 16'h0, 1'b1, 32'hDEAD_BEEF, 32'h0000_0000, 2'b01);
        run_seq("R5", 1'b0, 16'h0, 1'b1, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 2'b00);
    endtask

    task automatic t_skip();  // R6
        run_seq("R6", 1'b1, 16'h0456, 1'b0, 32'h1111_1111, 32'hFFFF, 2'b01);
        run_seq("R6", 1'b0, 16'h0456, 1'b0, 32'h1111_1111, 32'hFFFF, 2'b01);
        chk("R6", n_busy, 1, "busy cycles with nothing to send");
    endtask

    task automatic t_timeout();  // R8
        respond = 1'b0;
        run_seq("R8", 1'b1, 16'h0BCD, 1'b1, 32'h0000_0042, 32'h0, 2'b01);
        chk("R8", n_busy, n_exp * (2 + CLK_MHZ * POLL_LIMIT) + 1, "busy cycles on timeout");
        chk("R8", int'(tmo_err), 1, "tmo_err after timeout");
        respond = 1'b1;
        repeat (5) @(negedge clk);
        #1;
        chk("R8", int'(tmo_err), 1, "tmo_err held while idle");
        run_seq("R8", 1'b0, 16'h0, 1'b1, 32'h99, 32'h0, 2'b00);
        chk("R8", int'(tmo_err), 0, "tmo_err cleared by new start");
    endtask

    task automatic t_restart();  // R10
        build_exp(1'b1, 16'h0321, 1'b1, 32'h0000_5566, 32'h0000_FFFF, 2'b01);
        launch(1'b1, 16'h0321, 1'b1, 32'h0000_5566, 32'h0000_FFFF, 2'b01);
        repeat (4) @(negedge clk);
        #1;
        col = 16'h0FFF; page_addr = 32'hAAAA_AAAA; page_mode = 2'b10;
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        wait_done();
        cmp_bytes("R10");
        chk("R10", n_done, 1, "done pulses with extra start");
        chk("R9", int'(busy), 0, "busy low after done");
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_small();
        t_2k();
        t_4k();
        t_rows();
        t_skip();
        t_timeout();
        t_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule